// File: doc/BRIEF.md
# Auto-Reload Interval Timer

A 16-bit up-counter that runs permanently in auto-reload fashion. Each time it rolls over from FFFFh it takes its next value from a software-written reload register instead of zero, so the interval between rollovers is fixed by the reload value alone. A rollover sets a sticky flag that drives an interrupt request. The same rollover also produces a single-cycle start strobe for an analog-to-digital converter.

The count advances on a tick whose source is set in the control byte. There are three sources: every system clock cycle, one system cycle in twelve, or one rising edge in eight of an asynchronous external oscillator input. The external input is synchronised into the system clock domain. When the external source is selected, the divide-select bit has no effect. Clearing the run bit freezes the count and returns both prescalers to their start state.

Software reaches the control byte, the reload value and the count through separate write strobes and read ports. The system bus decoder is outside this block.

Top module: `reload_timer`

## Requirements
- R1: After reset, count_o, reload_o, ctrl_o, irq_o and conv_start_o are all zero.
- R2: With control bits run=1, div_sel=1 and ext_sel=0, the count increases by one on every clock cycle.
- R3: A tick while the count is FFFFh loads the reload value into the count and sets the overflow flag. Several consecutive rollovers are possible when the reload value is FFFFh.
- R4: Writing FFFFh to the count before starting makes the first tick load the reload value.
- R5: With ext_sel=0 and div_sel=0, the count advances once per 12 clock cycles of run time, counted from the cycle in which run takes effect.
- R6: With ext_sel=1, the count advances once per 8 rising edges of ext_osc_i, whatever div_sel holds. With no edges, the count does not move.
- R7: The overflow flag stays set until software writes 0 to bit 7. Hardware never clears it, and a rollover in the same cycle as such a write wins. irq_o equals the flag.
- R8: The control byte reads with the flag at bit 7, run at bit 2, div_sel at bit 1 and ext_sel at bit 0. Bits 6 to 3 always read 0.
- R9: While run reads 0, the count holds its value unless software writes it.
- R10: Each rollover drives conv_start_o high for exactly the one cycle in which the flag first reads set from that rollover.
- R11: A count write takes effect on the next clock edge and takes priority over a tick in the same cycle. A reload write takes effect on the next edge and reads back on reload_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_o | output | 8 | Control byte read value |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 16 | Reload write data |
| reload_o | output | 16 | Reload register read value |
| count_we_i | input | 1 | Count write strobe |
| count_wdata_i | input | 16 | Count write data |
| count_o | output | 16 | Current count |
| ext_osc_i | input | 1 | Asynchronous external oscillator input |
| irq_o | output | 1 | Interrupt request, level, equal to the overflow flag |
| conv_start_o | output | 1 | One-cycle converter start strobe on rollover |

## Verification
The hardest case to reach from the ports is a run of rollovers on consecutive cycles. Each one must reload, keep the flag set and give its own strobe. The stimulus reaches it by programming a reload value of FFFFh and running at full system rate, so every tick after the first wrap is another wrap. The bench counts strobe cycles against the expected number of rollovers. The external-source path is driven by slow edge trains, one exactly a multiple of eight and one a single edge short. These show that the divider counts synchronised rising edges and ignores the divide-select bit.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CTRL_W     = 8;
  localparam int BIT_FLAG   = 7;
  localparam int BIT_RUN    = 2;
  localparam int BIT_DIVSEL = 1;
  localparam int BIT_EXTSEL = 0;

  typedef struct packed {
    logic flag;
    logic run;
    logic div_sel;
    logic ext_sel;
  } ctrl_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_t c);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[BIT_FLAG]   = c.flag;
    v[BIT_RUN]    = c.run;
    v[BIT_DIVSEL] = c.div_sel;
    v[BIT_EXTSEL] = c.ext_sel;
    return v;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div_sel_i,
  input  logic ext_sel_i,
  input  logic ext_osc_i,
  output logic tick_o
);
  localparam int SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

  // synchroniser plus one stage for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic ext_rise;
  logic sys_tick;
  logic ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_osc_i};
  end
  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  generate
    if (SYS_DIV > 1) begin : g_sys_pre
      logic [SW-1:0] sys_cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          sys_cnt_q <= '0;
        else if (!run_i)                      sys_cnt_q <= '0;
        else if (sys_cnt_q == SW'(SYS_DIV-1)) sys_cnt_q <= '0;
        else                                  sys_cnt_q <= sys_cnt_q + 1'b1;
      end
      assign sys_tick = run_i & (sys_cnt_q == SW'(SYS_DIV-1));
    end else begin : g_sys_bypass
      assign sys_tick = run_i;
    end

    if (EXT_DIV > 1) begin : g_ext_pre
      logic [EW-1:0] ext_cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       ext_cnt_q <= '0;
        else if (!run_i)   ext_cnt_q <= '0;
        else if (ext_rise) ext_cnt_q <= (ext_cnt_q == EW'(EXT_DIV-1)) ? '0 : ext_cnt_q + 1'b1;
      end
      assign ext_tick = run_i & ext_rise & (ext_cnt_q == EW'(EXT_DIV-1));
    end else begin : g_ext_bypass
      assign ext_tick = run_i & ext_rise;
    end
  endgenerate

  always_comb begin
    if (!run_i)         tick_o = 1'b0;
    else if (ext_sel_i) tick_o = ext_tick;
    else if (div_sel_i) tick_o = 1'b1;
    else                tick_o = sys_tick;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (wrap_o) cnt_q <= reload_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CNT_W       = 16,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  output logic [7:0]       ctrl_o,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  output logic [CNT_W-1:0] reload_o,
  input  logic             count_we_i,
  input  logic [CNT_W-1:0] count_wdata_i,
  output logic [CNT_W-1:0] count_o,
  input  logic             ext_osc_i,
  output logic             irq_o,
  output logic             conv_start_o
);
  import timer_pkg::*;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             tick;
  logic             wrap;
  logic             conv_q;
  logic             unused_wbits;

  assign unused_wbits = ^ctrl_wdata_i[6:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q.run     <= ctrl_wdata_i[BIT_RUN];
        ctrl_q.div_sel <= ctrl_wdata_i[BIT_DIVSEL];
        ctrl_q.ext_sel <= ctrl_wdata_i[BIT_EXTSEL];
      end
      // rollover beats a software clear in the same cycle
      if (wrap)           ctrl_q.flag <= 1'b1;
      else if (ctrl_we_i) ctrl_q.flag <= ctrl_wdata_i[BIT_FLAG];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_q <= '0;
    else if (reload_we_i) reload_q <= reload_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= wrap;
  end

  tmr_tick_gen #(
    .SYS_DIV    (SYS_DIV),
    .EXT_DIV    (EXT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .div_sel_i(ctrl_q.div_sel),
    .ext_sel_i(ctrl_q.ext_sel),
    .ext_osc_i(ext_osc_i),
    .tick_o   (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (count_we_i),
    .load_val_i(count_wdata_i),
    .reload_i  (reload_q),
    .count_o   (count_o),
    .wrap_o    (wrap)
  );

  assign ctrl_o       = pack_ctrl(ctrl_q);
  assign reload_o     = reload_q;
  assign irq_o        = ctrl_q.flag;
  assign conv_start_o = conv_q;
endmodule

// File: rtl/reload_timer_check.sv
module reload_timer_check #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic             reload_we_i,
  input logic             count_we_i,
  input logic [7:0]       ctrl_o,
  input logic [CNT_W-1:0] reload_o,
  input logic [CNT_W-1:0] count_o,
  input logic             conv_start_o
);
  assert_sysclk_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2:0] == 3'b110 && !count_we_i && count_o != {CNT_W{1'b1}})
      |=> count_o == $past(count_o) + 1'b1);

  assert_reload_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && $past(!reload_we_i) && $past(!count_we_i)) |-> count_o == reload_o);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] && !ctrl_we_i) |=> ctrl_o[7]);

  assert_zero_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[6:3] == 4'b0000);

  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[2] && !count_we_i) |=> $stable(count_o));

  assert_strobe_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> ctrl_o[7]);
endmodule

bind reload_timer reload_timer_check #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .reload_we_i (reload_we_i),
  .count_we_i  (count_we_i),
  .ctrl_o      (ctrl_o),
  .reload_o    (reload_o),
  .count_o     (count_o),
  .conv_start_o(conv_start_o)
);

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rd;
  logic        reload_we = 1'b0;
  logic [15:0] reload_wdata = '0;
  logic [15:0] reload_rd;
  logic        count_we = 1'b0;
  logic [15:0] count_wdata = '0;
  logic [15:0] count_rd;
  logic        ext_osc = 1'b0;
  logic        irq;
  logic        conv_start;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  reload_timer u_reload_timer (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_rd),
    .reload_we_i(reload_we), .reload_wdata_i(reload_wdata), .reload_o(reload_rd),
    .count_we_i(count_we), .count_wdata_i(count_wdata), .count_o(count_rd),
    .ext_osc_i(ext_osc), .irq_o(irq), .conv_start_o(conv_start)
  );

  always @(negedge clk) if (conv_start) pulses++;

  // {start, reload, ticks, expected count, expected flag, expected strobes}
  localparam logic [60:0] VEC [6] = '{
    {16'h0010, 16'h0000, 8'd5,  16'h0015, 1'b0, 4'd0},
    {16'hFFFE, 16'h1234, 8'd1,  16'hFFFF, 1'b0, 4'd0},
    {16'hFFFE, 16'h1234, 8'd2,  16'h1234, 1'b1, 4'd1},
    {16'hFFFF, 16'hFFF6, 8'd1,  16'hFFF6, 1'b1, 4'd1},
    {16'hFFFF, 16'hFFF6, 8'd12, 16'hFFF7, 1'b1, 4'd2},
    {16'hFFFD, 16'hFFFF, 8'd5,  16'hFFFF, 1'b1, 4'd3}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(logic [15:0] start, logic [15:0] rl);
    @(negedge clk);
    pulses = 0;
    count_we = 1'b1; count_wdata = start;
    reload_we = 1'b1; reload_wdata = rl;
    ctrl_we = 1'b1; ctrl_wdata = 8'h00;
    @(negedge clk);
    count_we = 1'b0; reload_we = 1'b0; ctrl_we = 1'b0;
  endtask

  task automatic stop_run();
    ctrl_we = 1'b1; ctrl_wdata = ctrl_rd & ~8'h04;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // exactly n clock edges see run=1
  task automatic run_n(logic [7:0] ctrl, int n);
    ctrl_we = 1'b1; ctrl_wdata = ctrl;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (n - 1) @(negedge clk);
    stop_run();
  endtask

  task automatic ext_edges(int k);
    for (int e = 0; e < k; e++) begin
      ext_osc = 1'b1; repeat (3) @(negedge clk);
      ext_osc = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", count_rd, 0);
    check("R1 reload", reload_rd, 0);
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 irq", irq, 0);
    check("R1 strobe", conv_start, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 R3 R4 R10
    for (int i = 0; i < 6; i++) begin
      setup(VEC[i][60:45], VEC[i][44:29]);
      check("R11 reload readback", reload_rd, VEC[i][44:29]);
      run_n(8'h06, int'(VEC[i][28:21]));
      @(negedge clk);
      check("R2/R3/R4 count", count_rd, VEC[i][20:5]);
      check("R3 flag", ctrl_rd[7], VEC[i][4]);
      check("R7 irq equals flag", irq, VEC[i][4]);
      check("R10 strobe cycles", pulses, VEC[i][3:0]);
    end

    // R7 flag stays set across further counting, then software clears it
    run_n(8'h86, 3);
    repeat (2) @(negedge clk);
    check("R7 flag held", ctrl_rd[7], 1);
    ctrl_we = 1'b1; ctrl_wdata = 8'h00; @(negedge clk); ctrl_we = 1'b0;
    check("R7 flag cleared", ctrl_rd[7], 0);
    check("R7 irq cleared", irq, 0);

    // R8 layout: unused bits read zero
    ctrl_we = 1'b1; ctrl_wdata = 8'hFB; @(negedge clk); ctrl_we = 1'b0;
    check("R8 layout no run", ctrl_rd, 8'h83);
    ctrl_we = 1'b1; ctrl_wdata = 8'h00; @(negedge clk); ctrl_we = 1'b0;

    // R9 frozen while stopped
    setup(16'h4321, 16'h0000);
    repeat (10) @(negedge clk);
    check("R9 frozen", count_rd, 16'h4321);

    // R11 count write wins over a tick
    ctrl_we = 1'b1; ctrl_wdata = 8'h06; @(negedge clk); ctrl_we = 1'b0;
    count_we = 1'b1; count_wdata = 16'h0100; @(negedge clk); count_we = 1'b0;
    check("R11 write priority", count_rd, 16'h0100);
    stop_run();

    // R5 divide by 12
    setup(16'h0000, 16'h0000);
    run_n(8'h04, 23);
    @(negedge clk);
    check("R5 23 cycles", count_rd, 1);
    setup(16'h0000, 16'h0000);
    run_n(8'h04, 24);
    @(negedge clk);
    check("R5 24 cycles", count_rd, 2);

    // R6 external divide by 8, div_sel ignored
    setup(16'h0000, 16'h0000);
    ctrl_we = 1'b1; ctrl_wdata = 8'h07; @(negedge clk); ctrl_we = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 no edges no count", count_rd, 0);
    ext_edges(16);
    stop_run();
    check("R6 16 edges", count_rd, 2);
    setup(16'h0000, 16'h0000);
    ctrl_we = 1'b1; ctrl_wdata = 8'h05; @(negedge clk); ctrl_we = 1'b0;
    ext_edges(15);
    stop_run();
    check("R6 15 edges", count_rd, 1);

    // R10 single strobe on one rollover
    setup(16'hFFFF, 16'h0100);
    run_n(8'h06, 1);
    repeat (3) @(negedge clk);
    check("R10 one strobe", pulses, 1);
    check("R10 strobe low", conv_start, 0);
    held = count_rd;
    check("R4 loaded reload", held, 16'h0100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule